// File: doc/BRIEF.md
# Display Memory Access Sequencer

This block is the only master of an external byte-wide static RAM that holds display data. It accepts access requests from two clients, a display refresh port that only reads and a host port that reads or writes. It turns each accepted request into a fixed three-clock memory frame on a 16-bit address bus, an active-low chip enable, active-low read and write strobes and a bidirectional 8-bit data bus.

In every frame, chip enable stays high for the first clock and goes low for the next two. The address holds steady for all three clocks. A read frame pulls the read strobe low from the first clock, and the byte on the bus is captured at the end of the third clock. It is then handed to the client that asked for it with a one-cycle valid pulse. A write frame pulls the write strobe low and drives the write byte for all three clocks. The bus is left floating at all other times. When both clients ask in the same cycle, refresh wins. A new frame can follow the previous one with no idle clock.

A client keeps its request high until it sees its acknowledge. The acknowledge is combinational. It rises in the cycle the request is taken, which is any idle cycle or the last clock of a running frame. The reset input is asynchronous and active low. Its release is synchronised inside the block, which adds two clocks.

Top module: `vseq_top`

## Requirements
- R1: While reset is applied and until the first request is accepted, chip enable, read strobe and write strobe are high (inactive), and neither read-valid output pulses.
- R2: Every frame lasts exactly three clocks: chip enable is high on the first clock and low on the second and third. The address equals the accepted request's address and holds steady for all three clocks. Outputs appear on the clock after the acknowledge.
- R3: In a read frame the read strobe is low on all three clocks and the write strobe stays high.
- R4: In a write frame the write strobe is low on all three clocks, the read strobe stays high, and the bus carries the host's write byte on all three clocks.
- R5: In a read frame the bus value present during the third clock is captured at its end. It appears on rd_data in the following cycle, and the valid output of the requesting port (rf_rvalid or host_rvalid) is high for that single cycle.
- R6: When refresh and host requests are both high in a cycle where a frame may start, refresh is acknowledged and the host waits.
- R7: A request is acknowledged only in a cycle where the sequencer is idle or on the third clock of a frame. A request pending at the third clock starts the next frame with no gap.
- R8: With no request pending after a frame, all strobes return high and stay high.
- R9: The block drives the bus only during write frames, so a byte returned by the memory during a read frame reaches rd_data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rf_req | input | 1 | Refresh read request, held until acknowledged |
| rf_addr | input | 16 | Refresh read address |
| rf_ack | output | 1 | Refresh request accepted this cycle |
| host_req | input | 1 | Host request, held until acknowledged |
| host_we | input | 1 | Host request is a write (1) or read (0) |
| host_addr | input | 16 | Host address |
| host_wdata | input | 8 | Host write byte |
| host_ack | output | 1 | Host request accepted this cycle |
| rd_data | output | 8 | Captured read byte |
| rf_rvalid | output | 1 | rd_data belongs to a refresh read |
| host_rvalid | output | 1 | rd_data belongs to a host read |
| mem_addr | output | 16 | Memory address |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_rd_n | output | 1 | Memory read strobe, active low |
| mem_wr_n | output | 1 | Memory write strobe, active low |
| mem_dq | inout | 8 | Memory data bus |

## Verification
The sequencer is tried with four patterns, each compared every cycle against a behavioural model. Isolated host writes and reads with idle gaps show the basic frame shape and that stored bytes return intact. A queue of back-to-back refresh reads separates a gapless frame chain from one that inserts idle clocks. Requests raised together on both ports show whether refresh priority holds and whether the host waits rather than being dropped. A mixed stream of host writes and refresh reads of the same addresses shows whether read-after-write data comes back correctly and reaches the right valid output.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
  localparam int unsigned VS_ADDR_W = 16;
  localparam int unsigned VS_DATA_W = 8;
  localparam int unsigned VS_NSRC   = 2;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_HOLD1 = 2'd2,
    PH_HOLD2 = 2'd3
  } vseq_phase_e;

  typedef enum logic {
    SRC_RF   = 1'b0,
    SRC_HOST = 1'b1
  } vseq_src_e;

  typedef struct packed {
    logic      we;
    vseq_src_e src;
  } vseq_cmd_t;
endpackage

// File: rtl/vseq_arb.sv
module vseq_arb
  import vseq_pkg::*;
#(
  parameter int unsigned ADDR_W = VS_ADDR_W,
  parameter int unsigned DATA_W = VS_DATA_W
) (
  input  logic              slot_open,
  input  logic              rf_req,
  input  logic [ADDR_W-1:0] rf_addr,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              rf_ack,
  output logic              host_ack,
  output logic              start,
  output vseq_cmd_t         sel_cmd,
  output logic [ADDR_W-1:0] sel_addr,
  output logic [DATA_W-1:0] sel_wdata
);
  localparam int unsigned NSRC = VS_NSRC;

  logic [NSRC-1:0] req_vec;
  logic [NSRC-1:0] gnt_vec;
  logic [NSRC:0]   above;

  assign req_vec = {host_req, rf_req};
  assign above[0] = 1'b0;

  // index 0 (refresh) has the highest priority
  genvar gi;
  generate
    for (gi = 0; gi < NSRC; gi++) begin : g_prio
      assign gnt_vec[gi]  = slot_open & req_vec[gi] & ~above[gi];
      assign above[gi+1]  = above[gi] | req_vec[gi];
    end
  endgenerate

  assign rf_ack   = gnt_vec[0];
  assign host_ack = gnt_vec[1];
  assign start    = |gnt_vec;

  always_comb begin
    if (gnt_vec[0]) begin
      sel_cmd.we  = 1'b0;
      sel_cmd.src = SRC_RF;
      sel_addr    = rf_addr;
      sel_wdata   = '0;
    end else begin
      sel_cmd.we  = host_we;
      sel_cmd.src = SRC_HOST;
      sel_addr    = host_addr;
      sel_wdata   = host_wdata;
    end
  end
endmodule

// File: rtl/vseq_frame.sv
module vseq_frame
  import vseq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  output vseq_phase_e phase_q,
  output vseq_phase_e phase_d,
  output logic        slot_open,
  output logic        last
);
  always_comb begin
    if (start) begin
      phase_d = PH_SETUP;
    end else begin
      unique case (phase_q)
        PH_SETUP: phase_d = PH_HOLD1;
        PH_HOLD1: phase_d = PH_HOLD2;
        default:  phase_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  assign last      = (phase_q == PH_HOLD2);
  assign slot_open = (phase_q == PH_IDLE) | last;
endmodule

// File: rtl/vseq_drive.sv
module vseq_drive
  import vseq_pkg::*;
#(
  parameter int unsigned ADDR_W = VS_ADDR_W,
  parameter int unsigned DATA_W = VS_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  vseq_phase_e       phase_d,
  input  vseq_cmd_t         sel_cmd,
  input  logic [ADDR_W-1:0] sel_addr,
  input  logic [DATA_W-1:0] sel_wdata,
  output vseq_cmd_t         cmd_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic              ce_n_q,
  output logic              rd_n_q,
  output logic              wr_n_q,
  output logic              oe_q
);
  vseq_cmd_t         cmd_d;
  logic [ADDR_W-1:0] addr_d;
  logic [DATA_W-1:0] wdata_d;
  logic              active_d;
  logic              ce_n_d, rd_n_d, wr_n_d, oe_d;

  always_comb begin
    cmd_d    = start ? sel_cmd   : cmd_q;
    addr_d   = start ? sel_addr  : addr_q;
    wdata_d  = start ? sel_wdata : wdata_q;
    active_d = (phase_d != PH_IDLE);
    ce_n_d   = ~((phase_d == PH_HOLD1) | (phase_d == PH_HOLD2));
    rd_n_d   = ~(active_d & ~cmd_d.we);
    wr_n_d   = ~(active_d &  cmd_d.we);
    oe_d     = active_d & cmd_d.we;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      ce_n_q  <= 1'b1;
      rd_n_q  <= 1'b1;
      wr_n_q  <= 1'b1;
      oe_q    <= 1'b0;
    end else begin
      cmd_q   <= cmd_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      ce_n_q  <= ce_n_d;
      rd_n_q  <= rd_n_d;
      wr_n_q  <= wr_n_d;
      oe_q    <= oe_d;
    end
  end
endmodule

// File: rtl/vseq_capture.sv
module vseq_capture
  import vseq_pkg::*;
#(
  parameter int unsigned DATA_W = VS_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              last,
  input  vseq_cmd_t         cmd_q,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] rdata_q,
  output logic              rf_rv_q,
  output logic              host_rv_q
);
  logic              cap_en;
  logic [DATA_W-1:0] rdata_d;
  logic              rf_rv_d, host_rv_d;

  always_comb begin
    cap_en    = last & ~cmd_q.we;
    rdata_d   = cap_en ? dq_in : rdata_q;
    rf_rv_d   = cap_en & (cmd_q.src == SRC_RF);
    host_rv_d = cap_en & (cmd_q.src == SRC_HOST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q   <= '0;
      rf_rv_q   <= 1'b0;
      host_rv_q <= 1'b0;
    end else begin
      rdata_q   <= rdata_d;
      rf_rv_q   <= rf_rv_d;
      host_rv_q <= host_rv_d;
    end
  end
endmodule

// File: rtl/vseq_top.sv
module vseq_top
  import vseq_pkg::*;
#(
  parameter int unsigned ADDR_W = VS_ADDR_W,
  parameter int unsigned DATA_W = VS_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rf_req,
  input  logic [ADDR_W-1:0] rf_addr,
  output logic              rf_ack,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_ack,
  output logic [DATA_W-1:0] rd_data,
  output logic              rf_rvalid,
  output logic              host_rvalid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_rd_n,
  output logic              mem_wr_n,
  inout  wire  [DATA_W-1:0] mem_dq
);
  localparam int unsigned SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  logic              slot_open, start, last;
  vseq_phase_e       phase_q, phase_d;
  vseq_cmd_t         sel_cmd, cmd_q;
  logic [ADDR_W-1:0] sel_addr;
  logic [DATA_W-1:0] sel_wdata, wdata_q;
  logic              oe_q;

  vseq_arb #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arb (
    .slot_open (slot_open),
    .rf_req    (rf_req),
    .rf_addr   (rf_addr),
    .host_req  (host_req),
    .host_we   (host_we),
    .host_addr (host_addr),
    .host_wdata(host_wdata),
    .rf_ack    (rf_ack),
    .host_ack  (host_ack),
    .start     (start),
    .sel_cmd   (sel_cmd),
    .sel_addr  (sel_addr),
    .sel_wdata (sel_wdata)
  );

  vseq_frame u_frame (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .start    (start),
    .phase_q  (phase_q),
    .phase_d  (phase_d),
    .slot_open(slot_open),
    .last     (last)
  );

  vseq_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drive (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .start    (start),
    .phase_d  (phase_d),
    .sel_cmd  (sel_cmd),
    .sel_addr (sel_addr),
    .sel_wdata(sel_wdata),
    .cmd_q    (cmd_q),
    .addr_q   (mem_addr),
    .wdata_q  (wdata_q),
    .ce_n_q   (mem_ce_n),
    .rd_n_q   (mem_rd_n),
    .wr_n_q   (mem_wr_n),
    .oe_q     (oe_q)
  );

  vseq_capture #(.DATA_W(DATA_W)) u_cap (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .last     (last),
    .cmd_q    (cmd_q),
    .dq_in    (mem_dq),
    .rdata_q  (rd_data),
    .rf_rv_q  (rf_rvalid),
    .host_rv_q(host_rvalid)
  );

  assign mem_dq = oe_q ? wdata_q : {DATA_W{1'bz}};
endmodule

// File: rtl/vseq_checker.sv
module vseq_checker #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rf_req,
  input logic              rf_ack,
  input logic              host_ack,
  input logic              rf_rvalid,
  input logic              host_rvalid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_rd_n,
  input logic              mem_wr_n
);
  AST_CE_LOW_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ce_n) |=> !mem_ce_n); // R2
  AST_CE_LOW_MAX_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |=> mem_ce_n); // R2
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |-> $stable(mem_addr)); // R2
  AST_CE_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |-> (!mem_rd_n || !mem_wr_n)); // R3
  AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_rd_n && !mem_wr_n)); // R4
  AST_RVALID_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rf_rvalid, host_rvalid})); // R5
  AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_rvalid || host_rvalid) |-> $past(!mem_ce_n && !mem_rd_n)); // R5
  AST_REFRESH_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    host_ack |-> (!rf_req && !rf_ack)); // R6
endmodule

bind vseq_top vseq_checker #(.ADDR_W(ADDR_W)) u_vseq_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rf_req     (rf_req),
  .rf_ack     (rf_ack),
  .host_ack   (host_ack),
  .rf_rvalid  (rf_rvalid),
  .host_rvalid(host_rvalid),
  .mem_addr   (mem_addr),
  .mem_ce_n   (mem_ce_n),
  .mem_rd_n   (mem_rd_n),
  .mem_wr_n   (mem_wr_n)
);

// File: tb/vseq_top_tb_top.sv
`timescale 1ns/1ps
module vseq_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rf_req = 1'b0;
  logic [15:0] rf_addr = '0;
  logic        host_req = 1'b0;
  logic        host_we = 1'b0;
  logic [15:0] host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic        rf_ack, host_ack, rf_rvalid, host_rvalid;
  logic [7:0]  rd_data;
  logic [15:0] mem_addr;
  logic        mem_ce_n, mem_rd_n, mem_wr_n;
  wire  [7:0]  mem_dq;

  always #2.5 clk = ~clk;

  vseq_top dut_i (
    .clk(clk), .rst_n(rst_n),
    .rf_req(rf_req), .rf_addr(rf_addr), .rf_ack(rf_ack),
    .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_ack(host_ack),
    .rd_data(rd_data), .rf_rvalid(rf_rvalid), .host_rvalid(host_rvalid),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_rd_n(mem_rd_n),
    .mem_wr_n(mem_wr_n), .mem_dq(mem_dq)
  );

  // external memory: 256 bytes indexed by the low address byte
  logic [7:0] sram [256];
  logic       sram_drive;
  assign sram_drive = !mem_ce_n && !mem_rd_n;
  assign mem_dq = sram_drive ? sram[mem_addr[7:0]] : 8'bz;

  int tests = 0;
  int fails = 0;

  // request queues
  logic [15:0] rf_q[$];
  logic [24:0] h_q[$];   // {we, addr, wdata}

  // reference model state
  int          m_ph = 0;
  logic        m_we = 1'b0;
  logic        m_src = 1'b0;
  logic [15:0] m_addr = '0;
  logic [7:0]  m_wdata = '0;
  logic        m_rv_rf = 1'b0, m_rv_h = 1'b0;
  logic [7:0]  m_rdata = '0;
  logic [7:0]  exp_mem [256];
  int          host_wait = 0;
  int          cyc = 0;
  logic        saw_prio = 1'b0;

  initial begin
    for (int i = 0; i < 256; i++) begin
      sram[i]    = 8'((i * 37 + 11) ^ 8'h5A);
      exp_mem[i] = 8'((i * 37 + 11) ^ 8'h5A);
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s cyc=%0d actual=%0h expected=%0h", tag, cyc, act, exp_v);
    end
  endtask

  // memory write side of the model memory
  always @(negedge clk) begin
    if (!mem_ce_n && !mem_wr_n) sram[mem_addr[7:0]] = mem_dq;
  end

  // model update on the clock edge
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_ph = 0; m_rv_rf = 0; m_rv_h = 0;
    end else begin
      m_rv_rf = (m_ph == 3) && !m_we && !m_src;
      m_rv_h  = (m_ph == 3) && !m_we &&  m_src;
      if ((m_ph == 3) && !m_we) m_rdata = exp_mem[m_addr[7:0]];
      if ((m_ph == 3) &&  m_we) exp_mem[m_addr[7:0]] = m_wdata;
      if ((m_ph == 0 || m_ph == 3) && rf_req) begin
        m_ph = 1; m_we = 0; m_src = 0; m_addr = rf_addr;
        void'(rf_q.pop_front());
      end else if ((m_ph == 0 || m_ph == 3) && host_req) begin
        m_ph = 1; m_we = host_we; m_src = 1; m_addr = host_addr; m_wdata = host_wdata;
        void'(h_q.pop_front());
      end else if (m_ph == 0 || m_ph == 3) begin
        m_ph = 0;
      end else begin
        m_ph++;
      end
    end
  end

  // compare outputs, then drive requests, then compare acknowledges
  always @(negedge clk) begin
    logic exp_ce_n, exp_rd_n, exp_wr_n, open, g_rf, g_h;
    if (!rst_n) begin
      chk(mem_ce_n && mem_rd_n && mem_wr_n && !rf_rvalid && !host_rvalid,
          "R1 reset outputs", {mem_ce_n, mem_rd_n, mem_wr_n, rf_rvalid, host_rvalid}, 5'b11100);
    end else begin
      exp_ce_n = !(m_ph == 2 || m_ph == 3);
      exp_rd_n = !(m_ph != 0 && !m_we);
      exp_wr_n = !(m_ph != 0 &&  m_we);
      chk(mem_ce_n == exp_ce_n, "R2 chip enable phase", mem_ce_n, exp_ce_n);
      chk(mem_rd_n == exp_rd_n, "R3 read strobe", mem_rd_n, exp_rd_n);
      chk(mem_wr_n == exp_wr_n, "R4 write strobe", mem_wr_n, exp_wr_n);
      if (m_ph == 0)
        chk(mem_ce_n && mem_rd_n && mem_wr_n, "R8 idle strobes high",
            {mem_ce_n, mem_rd_n, mem_wr_n}, 3'b111);
      if (m_ph != 0)
        chk(mem_addr == m_addr, "R2 address held", mem_addr, m_addr);
      if (m_ph != 0 && m_we)
        chk(mem_dq == m_wdata, "R4 write data on bus", mem_dq, m_wdata);
      chk(rf_rvalid == m_rv_rf && host_rvalid == m_rv_h, "R5 valid pulse",
          {rf_rvalid, host_rvalid}, {m_rv_rf, m_rv_h});
      if (m_rv_rf || m_rv_h)
        chk(rd_data == m_rdata, "R9 read data intact", rd_data, m_rdata);
    end
    // drive requests from queue heads
    rf_req  = (rf_q.size() != 0);
    rf_addr = rf_req ? rf_q[0] : 16'h0;
    host_req = (h_q.size() != 0);
    if (host_req) {host_we, host_addr, host_wdata} = h_q[0];
    #1;
    if (rst_n) begin
      open = (m_ph == 0 || m_ph == 3);
      g_rf = open && rf_req;
      g_h  = open && !rf_req && host_req;
      chk(rf_ack == g_rf, "R7 refresh acknowledge", rf_ack, g_rf);
      chk(host_ack == g_h, "R7 host acknowledge", host_ack, g_h);
      if (open && rf_req && host_req) begin
        saw_prio = 1'b1;
        chk(rf_ack && !host_ack, "R6 refresh wins", {rf_ack, host_ack}, 2'b10);
      end
    end
  end

  task automatic wait_drain();
    while (rf_q.size() != 0 || h_q.size() != 0 || m_ph != 0) @(posedge clk);
    repeat (3) @(posedge clk);
  endtask

  task automatic push_h(input bit we, input logic [15:0] a, input logic [7:0] d);
    h_q.push_back({we, a, d});
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (6) @(posedge clk);
    #2;
    // isolated host write then read of the same address
    push_h(1'b1, 16'h1212, 8'hA5);
    wait_drain(); #2;
    push_h(1'b0, 16'h3412, 8'h00);
    wait_drain(); #2;
    // back-to-back refresh reads
    for (int i = 0; i < 6; i++) rf_q.push_back(16'(16'h0100 + i * 3));
    wait_drain(); #2;
    // both ports at once
    rf_q.push_back(16'h0040);
    rf_q.push_back(16'h0041);
    push_h(1'b0, 16'h0042, 8'h00);
    push_h(1'b1, 16'h0043, 8'h3C);
    wait_drain(); #2;
    // mixed stream, reads after writes of the same addresses
    for (int i = 0; i < 8; i++) begin
      push_h(1'b1, 16'(16'h2000 + i), 8'(8'hC0 + i * 5));
      rf_q.push_back(16'(16'h2000 + i));
      push_h(1'b0, 16'(16'h2000 + i), 8'h00);
    end
    wait_drain();
    if (!saw_prio) begin
      tests++; fails++;
      $display("FAIL R6 no simultaneous request seen actual=0 expected=1");
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule